// File: doc/BRIEF.md
# Byte-Stream UART Register Front End

This block gives a processor the register view of a classic 8250/16550-style serial port while exchanging whole bytes with the rest of the chip over two valid/ready byte streams instead of a serial line. Registers sit on a four-byte stride. A latch-select bit in the line control register swaps the two lowest offsets between the data and interrupt-enable registers and the two halves of the baud divisor. The block has no serialiser, baud clock, FIFO or parity logic.

Reading the data offset takes one byte from the receive stream. Writing it hands one byte to the transmit stream in the same cycle. The line status register shows the live stream state at the time of the read. Two request outputs tell an interrupt controller that the transmitter can take a byte or that a received byte is waiting. When the controller accepts a request it pulses a grant input, and the identity register then records which source was served. The modem control register has a loopback mode that copies its lines into the modem status register.

Top module: `uart_regfront`

## Requirements
- R1: After reset IER, LCR, MCR and MSR read 0x00 and IIR reads 0x01. With tx_ready=1 and rx_valid=0, LSR (offset 0x14) reads 0x60.
- R2: When LCR bit 7 is 1, offset 0x0 reads and writes the divisor low byte and offset 0x4 reads and writes the divisor high byte. Neither access touches either stream. LCR (offset 0xC) reads back the full byte that was written to it.
- R3: When LCR bit 7 is 0, a write to offset 0x0 drives tx_valid high for that cycle with tx_data equal to the written byte. A read of offset 0x0 returns rx_data and drives rx_ready high when rx_valid is 1. If rx_valid is 0 the read returns 0x00.
- R4: When LCR bit 7 is 0, offset 0x4 reads and writes IER without changing the divisor bytes.
- R5: LSR reads {0, tx_ready, 1, 0000, rx_valid}: bit 6 is tx_ready and bit 0 is rx_valid, both sampled during the read.
- R6: A write to MCR (offset 0x10) with bit 4 set sets MSR bits 7 and 3 to MCR bit 3, bits 6 and 2 to MCR bit 2, bits 5 and 1 to MCR bit 0, and bits 4 and 0 to MCR bit 1. MCR reads back the written byte.
- R7: A write to MCR with bit 4 clear sets MSR (offset 0x18) to 0x30.
- R8: Writes to offsets 0x14, 0x18 and 0x1C and to undefined offsets change nothing. Offset 0x1C, offset 0xF8 and every undefined offset read 0x00.
- R9: irq_tx_req equals IER bit 1 AND tx_ready. irq_rx_req equals IER bit 0 AND rx_valid.
- R10: On an irq_grant pulse with IER bits 3:0 not all zero, IIR (offset 0x8) becomes 0x02 if irq_tx_req is high, otherwise 0x04 if irq_rx_req is high, otherwise 0x01. With IER bits 3:0 all zero, a grant leaves IIR unchanged.
- R11: A write to offset 0x8 does not change IIR or any other readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| tx_data | output | 8 | Byte offered to the transmit stream |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmit stream can take a byte |
| rx_data | input | 8 | Byte from the receive stream |
| rx_valid | input | 1 | Receive byte available |
| rx_ready | output | 1 | Receive byte consumed |
| irq_tx_req | output | 1 | Transmit-empty request |
| irq_rx_req | output | 1 | Receive-available request |
| irq_grant | input | 1 | Request accepted, updates IIR |

## Verification
The assertions check on every cycle that IIR only ever holds one of its three legal codes, that it changes only on a grant, that a grant with the transmit request active loads 0x02, that the divisor low byte changes only on a latched write, and that every MCR write leaves MSR in its loopback or fixed pattern. Only the bench scenarios can show the value each address returns, the latch-select swap of offsets 0x0 and 0x4, the live sampling of line status, the exact loopback bit routing, and that writes to read-only, scratch and undefined offsets have no effect.

// File: rtl/ufe_pkg.sv
package ufe_pkg;
  localparam int OFF_DATA  = 'h00;
  localparam int OFF_IER   = 'h04;
  localparam int OFF_IDENT = 'h08;
  localparam int OFF_LCR   = 'h0C;
  localparam int OFF_MCR   = 'h10;
  localparam int OFF_LSR   = 'h14;
  localparam int OFF_MSR   = 'h18;
  localparam int OFF_SCR   = 'h1C;

  localparam logic [7:0] IIR_NONE = 8'h01;
  localparam logic [7:0] IIR_TX   = 8'h02;
  localparam logic [7:0] IIR_RX   = 8'h04;
  localparam logic [7:0] MSR_FIXED = 8'h30;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DATA, SEL_IER, SEL_IDENT, SEL_LCR,
    SEL_MCR, SEL_LSR, SEL_MSR, SEL_SCR
  } reg_sel_e;

  // Loopback: each control line lands on a state bit and its delta bit
  function automatic logic [7:0] loop_status(input logic [7:0] ctl);
    logic [3:0] half;
    half = {ctl[3], ctl[2], ctl[0], ctl[1]};
    return {half, half};
  endfunction

  function automatic logic [7:0] line_status(input logic rx_avail, input logic tx_free);
    return {1'b0, tx_free, 1'b1, 4'b0000, rx_avail};
  endfunction

  function automatic logic [7:0] ident_pick(input logic tx_req, input logic rx_req);
    if (tx_req)      return IIR_TX;
    else if (rx_req) return IIR_RX;
    else             return IIR_NONE;
  endfunction
endpackage

// File: rtl/ufe_addr_dec.sv
module ufe_addr_dec
  import ufe_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    if      (addr == ADDR_W'(OFF_DATA))  sel = SEL_DATA;
    else if (addr == ADDR_W'(OFF_IER))   sel = SEL_IER;
    else if (addr == ADDR_W'(OFF_IDENT)) sel = SEL_IDENT;
    else if (addr == ADDR_W'(OFF_LCR))   sel = SEL_LCR;
    else if (addr == ADDR_W'(OFF_MCR))   sel = SEL_MCR;
    else if (addr == ADDR_W'(OFF_LSR))   sel = SEL_LSR;
    else if (addr == ADDR_W'(OFF_MSR))   sel = SEL_MSR;
    else if (addr == ADDR_W'(OFF_SCR))   sel = SEL_SCR;
    else                                 sel = SEL_NONE;
  end
endmodule

// File: rtl/ufe_modem.sv
module ufe_modem
  import ufe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mcr_wr,
  input  logic [7:0] wdata,
  output logic [7:0] mcr_q,
  output logic [7:0] msr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcr_q <= 8'h00;
      msr_q <= 8'h00;
    end else if (mcr_wr) begin
      mcr_q <= wdata;
      msr_q <= wdata[4] ? loop_status(wdata) : MSR_FIXED;
    end
  end

  p_msr_loop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mcr_wr && wdata[4]) |=> (msr_q[7:4] == msr_q[3:0] && msr_q[7] == mcr_q[3]));
  p_msr_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mcr_wr && !wdata[4]) |=> (msr_q == 8'h30));
endmodule

// File: rtl/ufe_irq.sv
module ufe_irq
  import ufe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] ier_en,
  input  logic       tx_ready,
  input  logic       rx_valid,
  input  logic       grant,
  output logic       tx_req,
  output logic       rx_req,
  output logic [7:0] iir_q
);
  logic any_en;
  assign any_en = |ier_en;
  assign tx_req = ier_en[1] & tx_ready;
  assign rx_req = ier_en[0] & rx_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               iir_q <= IIR_NONE;
    else if (grant && any_en) iir_q <= ident_pick(tx_req, rx_req);
  end

  p_iir_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_q[7:3] == 5'd0) && $onehot0(iir_q[2:0]) && (iir_q[2:0] != 3'b000));
  p_iir_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !grant |=> $stable(iir_q));
  p_iir_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && tx_req) |=> (iir_q == 8'h02));
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import ufe_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic              irq_tx_req,
  output logic              irq_rx_req,
  input  logic              irq_grant
);
  reg_sel_e   sel;
  logic       dlab;
  logic [7:0] lcr_q, dll_q, dlh_q, ier_q, mcr_q, msr_q, iir_q;

  // named access events
  logic ev_dll_wr, ev_dlh_wr, ev_thr_wr, ev_ier_wr, ev_lcr_wr, ev_mcr_wr, ev_rbr_rd;

  ufe_addr_dec #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr), .sel(sel));

  assign dlab      = lcr_q[7];
  assign ev_dll_wr = bus_wr && (sel == SEL_DATA) &&  dlab;
  assign ev_thr_wr = bus_wr && (sel == SEL_DATA) && !dlab;
  assign ev_dlh_wr = bus_wr && (sel == SEL_IER)  &&  dlab;
  assign ev_ier_wr = bus_wr && (sel == SEL_IER)  && !dlab;
  assign ev_lcr_wr = bus_wr && (sel == SEL_LCR);
  assign ev_mcr_wr = bus_wr && (sel == SEL_MCR);
  assign ev_rbr_rd = bus_rd && (sel == SEL_DATA) && !dlab;

  assign tx_valid = ev_thr_wr;
  assign tx_data  = bus_wdata;
  assign rx_ready = ev_rbr_rd && rx_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q <= 8'h00;
      dll_q <= 8'h00;
      dlh_q <= 8'h00;
      ier_q <= 8'h00;
    end else begin
      if (ev_lcr_wr) lcr_q <= bus_wdata;
      if (ev_dll_wr) dll_q <= bus_wdata;
      if (ev_dlh_wr) dlh_q <= bus_wdata;
      if (ev_ier_wr) ier_q <= bus_wdata;
    end
  end

  ufe_modem u_modem (
    .clk(clk), .rst_n(rst_n), .mcr_wr(ev_mcr_wr), .wdata(bus_wdata),
    .mcr_q(mcr_q), .msr_q(msr_q)
  );

  ufe_irq u_irq (
    .clk(clk), .rst_n(rst_n), .ier_en(ier_q[3:0]), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .grant(irq_grant), .tx_req(irq_tx_req),
    .rx_req(irq_rx_req), .iir_q(iir_q)
  );

  always_comb begin
    unique case (sel)
      SEL_DATA:  bus_rdata = dlab ? dll_q : (rx_valid ? rx_data : 8'h00);
      SEL_IER:   bus_rdata = dlab ? dlh_q : ier_q;
      SEL_IDENT: bus_rdata = iir_q;
      SEL_LCR:   bus_rdata = lcr_q;
      SEL_MCR:   bus_rdata = mcr_q;
      SEL_LSR:   bus_rdata = line_status(rx_valid, tx_ready);
      SEL_MSR:   bus_rdata = msr_q;
      default:   bus_rdata = 8'h00;
    endcase
  end

  p_div_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_dll_wr |=> $stable(dll_q));
  p_ier_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_ier_wr |=> $stable(ier_q));
endmodule

// File: tb/tb_uart_regfront.sv
module tb_uart_regfront;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] bus_addr = 0;
  logic       bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata, tx_data;
  logic       tx_valid, rx_ready, irq_tx_req, irq_rx_req;
  logic       tx_ready = 1;
  logic [7:0] rx_data = 0;
  logic       rx_valid = 0;
  logic       irq_grant = 0;

  int errors = 0, checks = 0, pops = 0;
  logic [7:0] rd_exp_q[$];
  string      rd_tag_q[$];
  logic [7:0] tx_exp_q[$];

  always #5 clk = ~clk;

  uart_regfront dut (.*);

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1 bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1 bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1 bus_addr = a; bus_rd = 1;
    rd_exp_q.push_back(exp); rd_tag_q.push_back(tag);
    @(posedge clk); #1 bus_rd = 0;
  endtask

  task automatic grant();
    @(posedge clk); #1 irq_grant = 1;
    @(posedge clk); #1 irq_grant = 0;
  endtask

  // monitor: read data, transmit pushes, receive pops
  always @(negedge clk) begin
    if (bus_rd) begin
      if (rd_exp_q.size() == 0) chk(bus_rdata, 8'hxx, "unexpected read");
      else chk(bus_rdata, rd_exp_q.pop_front(), rd_tag_q.pop_front());
    end
    if (tx_valid) begin
      if (tx_exp_q.size() == 0) chk(tx_data, 8'h00, "R2/R3 unexpected tx push");
      else chk(tx_data, tx_exp_q.pop_front(), "R3 tx byte");
    end
    if (rx_ready && rx_valid) pops++;
  end

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd(8'h04, 8'h00, "R1 IER"); rd(8'h08, 8'h01, "R1 IIR");
    rd(8'h0C, 8'h00, "R1 LCR"); rd(8'h10, 8'h00, "R1 MCR");
    rd(8'h18, 8'h00, "R1 MSR"); rd(8'h14, 8'h60, "R1 LSR");
    rd(8'h1C, 8'h00, "R1 scratch");
    // R2 divisor latch
    wr(8'h0C, 8'h83); rd(8'h0C, 8'h83, "R2 LCR");
    rx_valid = 1; rx_data = 8'h99;
    wr(8'h00, 8'h12); wr(8'h04, 8'h34);
    rd(8'h00, 8'h12, "R2 DLL"); rd(8'h04, 8'h34, "R2 DLH");
    @(negedge clk); chk(8'(pops), 8'd0, "R2 no pop under latch");
    rx_valid = 0;
    // R3/R4 data and IER
    wr(8'h0C, 8'h03);
    tx_exp_q.push_back(8'hA5); wr(8'h00, 8'hA5);
    tx_exp_q.push_back(8'h3C); wr(8'h00, 8'h3C);
    wr(8'h04, 8'h03); rd(8'h04, 8'h03, "R4 IER");
    rd(8'h00, 8'h00, "R3 empty rx read");
    rx_valid = 1; rx_data = 8'h5C;
    rd(8'h00, 8'h5C, "R3 rx byte");
    @(negedge clk); chk(8'(pops), 8'd1, "R3 one pop");
    wr(8'h0C, 8'h80); rd(8'h00, 8'h12, "R4 DLL kept"); rd(8'h04, 8'h34, "R4 DLH kept");
    wr(8'h0C, 8'h00);
    // R5 live line status
    tx_ready = 0; rd(8'h14, 8'h21, "R5 LSR rx");
    rx_valid = 0; tx_ready = 1; rd(8'h14, 8'h60, "R5 LSR tx");
    // R9 requests and R10 grant
    @(negedge clk); chk(irq_tx_req, 1, "R9 tx req"); chk(irq_rx_req, 0, "R9 rx req off");
    grant(); rd(8'h08, 8'h02, "R10 IIR tx");
    tx_ready = 0; rx_valid = 1;
    @(negedge clk); chk(irq_tx_req, 0, "R9 tx req off"); chk(irq_rx_req, 1, "R9 rx req");
    grant(); rd(8'h08, 8'h04, "R10 IIR rx");
    tx_ready = 1;
    grant(); rd(8'h08, 8'h02, "R10 tx priority");
    tx_ready = 0; rx_valid = 0;
    grant(); rd(8'h08, 8'h01, "R10 IIR none");
    tx_ready = 1; wr(8'h04, 8'h02); grant(); rd(8'h08, 8'h02, "R10 IIR tx again");
    wr(8'h04, 8'h00); tx_ready = 1; rx_valid = 1;
    @(negedge clk); chk(irq_tx_req, 0, "R9 masked tx"); chk(irq_rx_req, 0, "R9 masked rx");
    grant(); rd(8'h08, 8'h02, "R10 disabled hold");
    rx_valid = 0;
    wr(8'h04, 8'h08); grant(); rd(8'h08, 8'h01, "R10 enabled no source");
    // R6/R7 modem
    wr(8'h10, 8'h1B); rd(8'h18, 8'hBB, "R6 loop 1B"); rd(8'h10, 8'h1B, "R6 MCR");
    wr(8'h10, 8'h14); rd(8'h18, 8'h44, "R6 loop 14");
    wr(8'h10, 8'h11); rd(8'h18, 8'h22, "R6 loop 11");
    wr(8'h10, 8'h02); rd(8'h18, 8'h30, "R7 fixed"); rd(8'h10, 8'h02, "R7 MCR");
    // R8/R11 ignored writes
    wr(8'h14, 8'hFF); rd(8'h14, 8'h60, "R8 LSR");
    wr(8'h18, 8'h00); rd(8'h18, 8'h30, "R8 MSR");
    wr(8'h1C, 8'h77); rd(8'h1C, 8'h00, "R8 scratch");
    wr(8'h20, 8'h55); rd(8'h20, 8'h00, "R8 undefined");
    rd(8'hF8, 8'h00, "R8 F8");
    wr(8'h08, 8'hC7); rd(8'h08, 8'h01, "R11 IIR");
    rd(8'h0C, 8'h00, "R11 LCR"); rd(8'h04, 8'h08, "R11 IER");
    repeat (3) @(posedge clk);
    chk(8'(tx_exp_q.size()), 8'd0, "R3 all tx seen");
    chk(8'(rd_exp_q.size()), 8'd0, "reads all seen");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule